// File: doc/BRIEF.md
# Separable Chirp Pre-Multiplier

This block makes one pass over an N×N array of complex samples that sits in an on-chip RAM and scales every sample, in place, by a two-dimensional phase factor. The factor is separable. One part depends only on the column of the sample and the other only on its row. Each part is held in its own table of N complex coefficients, loaded beforehand through a small write port. The block reads the array in raster order, one sample per cycle. It multiplies each sample by its column coefficient and then by its row coefficient in a pipelined fixed-point chain. It writes the product back to the address the sample came from.

A controller loads both tables while the block is idle, then pulses `start`. The block reports `busy` for the whole pass and pulses `done` once the last result is in the RAM. The RAM is external. It must give a one-cycle read latency and accept one read and one write per cycle. Samples and coefficients are packed with the real part in the upper half of the word.

Top module: `chirp_premul`

## Requirements
- R1: While reset is asserted, and afterwards until a pass begins, `busy`, `done`, `rd_en` and `wr_en` are all low.
- R2: A `start` sampled high at a clock edge while `busy` is low begins a pass. `busy` rises at that edge, and the first read (`rd_en` high) is issued in the cycle that follows it.
- R3: The reads of a pass issue on N² consecutive cycles at addresses 0, 1, …, N²−1. The address is row×N + column, with the column in the low log2(N) bits, so the column runs fastest.
- R4: The value written for a sample x at column c and row r is (x·C[c])·R[r]. Each complex product is formed exactly, then rounded by adding 2^(W−2) and shifting arithmetically right by W−1, then saturated to the signed W-bit range. Coefficients are signed fractions with W−1 fraction bits. Every word packs the real part in bits [2W−1:W] and the imaginary part in bits [W−1:0].
- R5: Every write has `wr_addr` equal to the read address issued exactly 3 cycles earlier, and exactly one write occurs for each read.
- R6: From the first read cycle to the last write cycle inclusive, a pass spans N²+3 cycles.
- R7: `done` is high for exactly one cycle, the cycle right after the last write, and `busy` is low in that cycle.
- R8: A `start` while `busy` is high is ignored. The pass continues unchanged, with N² reads in total and a single `done`.
- R9: With `busy` low, `tbl_we` writes `tbl_data` to entry `tbl_idx` of the column table when `tbl_sel` is 0, or of the row table when `tbl_sel` is 1. Table writes while `busy` is high are ignored.
- R10: Saturation applies at each of the two steps. With both coefficients equal to −1 (real −2^(W−1), imaginary 0), a sample of real −2^(W−1) becomes 2^(W−1)−1 after the first step and is written as −(2^(W−1)−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the last write |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | 2·log2(N) | RAM read address |
| rd_data | input | 2W | RAM read data, one cycle after the address |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 2·log2(N) | RAM write address |
| wr_data | output | 2W | RAM write data |
| tbl_we | input | 1 | Coefficient table write strobe |
| tbl_sel | input | 1 | 0 selects the column table, 1 the row table |
| tbl_idx | input | log2(N) | Coefficient table entry |
| tbl_data | input | 2W | Coefficient value |

## Verification
The first read is due in the cycle after the edge that samples `start`. Each write is due three cycles after its read, and `done` is due one cycle after the final write. The bench logs the cycle number of every strobe at the falling edge, where the outputs have settled. It compares those numbers with the start cycle plus the intervals above. Write addresses are matched against the read address logged three cycles earlier. Data is compared only after `done`, against a model of the rounding rule, so the check does not depend on the order of individual writes. The pokes made while busy go in about 40 cycles into a pass. Their effect is judged from the read count, the done count and the final RAM contents.

// File: rtl/chirp_premul.sv
module chirp_premul #(
  parameter int N = 16,
  parameter int W = 16,
  localparam int LG = $clog2(N),
  localparam int AW = 2 * LG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [2*W-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [2*W-1:0] wr_data,
  input  logic          tbl_we,
  input  logic          tbl_sel,
  input  logic [LG-1:0] tbl_idx,
  input  logic [2*W-1:0] tbl_data
);

  localparam int LAT = 3;
  localparam logic [AW-1:0] LAST_IDX = '1;
  localparam logic signed [2*W:0] RND  = {{(W+2){1'b0}}, 1'b1, {(W-2){1'b0}}};
  localparam logic signed [2*W:0] SMAX = {{(W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [2*W:0] SMIN = {{(W+2){1'b1}}, {(W-1){1'b0}}};

  function automatic logic [W-1:0] rsat(input logic signed [2*W:0] v);
    logic signed [2*W:0] t;
    t = (v + RND) >>> (W - 1);
    if (t > SMAX) return SMAX[W-1:0];
    if (t < SMIN) return SMIN[W-1:0];
    return t[W-1:0];
  endfunction

  function automatic logic [2*W-1:0] cmul(input logic [2*W-1:0] a, input logic [2*W-1:0] b);
    logic signed [2*W:0] ar, ai, br, bi, pr, pi;
    ar = {{(W+1){a[2*W-1]}}, a[2*W-1:W]};
    ai = {{(W+1){a[W-1]}},   a[W-1:0]};
    br = {{(W+1){b[2*W-1]}}, b[2*W-1:W]};
    bi = {{(W+1){b[W-1]}},   b[W-1:0]};
    pr = ar * br - ai * bi;
    pi = ar * bi + ai * br;
    return {rsat(pr), rsat(pi)};
  endfunction

  logic [2*W-1:0] col_tab [N];
  logic [2*W-1:0] row_tab [N];

  always_ff @(posedge clk)
    if (tbl_we && !busy) begin
      if (tbl_sel) row_tab[tbl_idx] <= tbl_data;
      else         col_tab[tbl_idx] <= tbl_data;
    end

  logic          rd_on;
  logic [AW-1:0] idx;
  logic          vld [1:LAT];
  logic          lst [1:LAT];
  logic [AW-1:0] adr [1:LAT];

  assign rd_en   = rd_on;
  assign rd_addr = idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      rd_on <= 1'b0;
      idx   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy  <= 1'b1;
        rd_on <= 1'b1;
        idx   <= '0;
      end else if (rd_on) begin
        idx <= idx + 1'b1;
        if (idx == LAST_IDX) rd_on <= 1'b0;
      end
      if (vld[LAT] && lst[LAT]) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 1; i <= LAT; i++) begin
        vld[i] <= 1'b0;
        lst[i] <= 1'b0;
        adr[i] <= '0;
      end
    end else begin
      vld[1] <= rd_on;
      lst[1] <= rd_on && (idx == LAST_IDX);
      adr[1] <= idx;
      for (int i = 2; i <= LAT; i++) begin
        vld[i] <= vld[i-1];
        lst[i] <= lst[i-1];
        adr[i] <= adr[i-1];
      end
    end

  logic [2*W-1:0] cf, rf1, rf2, p, q;

  always_ff @(posedge clk) begin
    cf  <= col_tab[idx[LG-1:0]];
    rf1 <= row_tab[idx[AW-1:LG]];
    p   <= cmul(rd_data, cf);
    rf2 <= rf1;
    q   <= cmul(p, rf2);
  end

  assign wr_en   = vld[LAT];
  assign wr_addr = adr[LAT];
  assign wr_data = q;

endmodule

// File: rtl/chirp_premul_chk.sv
module chirp_premul_chk #(
  parameter int N = 16,
  localparam int AW = 2 * $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !wr_en));

  p_raster_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  p_write_trails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rd_en, 3) && wr_addr == $past(rd_addr, 3)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !busy));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(rd_en && rd_addr == '0));

endmodule

bind chirp_premul chirp_premul_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/chirp_premul_test.sv
module chirp_premul_test;
  localparam int N = 16, W = 16, NN = N * N, LAT = 3, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic tbl_we = 1'b0, tbl_sel = 1'b0;
  logic [3:0] tbl_idx = '0;
  logic [31:0] tbl_data = '0;

  always #2 clk = ~clk;

  chirp_premul uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_data(tbl_data)
  );

  logic [31:0] mem [NN];
  logic [31:0] orig [NN];
  logic [31:0] ctab [N];
  logic [31:0] rtab [N];

  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_rd, n_wr, n_done, first_rd, last_wr, done_cyc, ord_err, trail_err, done_busy;
  logic [AW-1:0] rd_log [8];

  always @(negedge clk) if (rst_n) begin
    if (rd_en) begin
      if (n_rd == 0) first_rd = cyc;
      if (rd_addr != n_rd[AW-1:0]) ord_err++;
      rd_log[cyc % 8] = rd_addr;
      n_rd++;
    end
    if (wr_en) begin
      if (wr_addr != rd_log[(cyc - LAT) % 8]) trail_err++;
      last_wr = cyc;
      n_wr++;
    end
    if (done) begin
      n_done++;
      done_cyc = cyc;
      if (busy) done_busy++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rs(input longint v);
    longint t;
    t = (v + 16384) >>> 15;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t[15:0];
  endfunction

  function automatic logic [31:0] cm(input logic [31:0] a, input logic [31:0] b);
    longint ar, ai, br, bi;
    ar = longint'($signed(a[31:16])); ai = longint'($signed(a[15:0]));
    br = longint'($signed(b[31:16])); bi = longint'($signed(b[15:0]));
    return {rs(ar * br - ai * bi), rs(ar * bi + ai * br)};
  endfunction

  task automatic tbl_put(input bit sel, input int i, input logic [31:0] d);
    tbl_we = 1'b1; tbl_sel = sel; tbl_idx = i[3:0]; tbl_data = d;
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic load_tables(input bit neg_one);
    for (int i = 0; i < N; i++) begin
      ctab[i] = neg_one ? 32'h8000_0000 : $urandom;
      rtab[i] = neg_one ? 32'h8000_0000 : $urandom;
      tbl_put(1'b0, i, ctab[i]);
      tbl_put(1'b1, i, rtab[i]);
    end
  endtask

  task automatic fill_ram();
    for (int i = 0; i < NN; i++) begin
      orig[i] = $urandom;
      if (i == 0) orig[i] = 32'h8000_0000;
      if (i == 1) orig[i] = 32'h7fff_7fff;
      mem[i] = orig[i];
    end
  endtask

  int sc;
  task automatic run_pass(input int poke);
    n_rd = 0; n_wr = 0; n_done = 0; ord_err = 0; trail_err = 0; done_busy = 0;
    first_rd = -1; last_wr = -1; done_cyc = -1;
    @(posedge clk); #1;
    start = 1'b1; sc = cyc;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    if (poke == 1) begin
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    if (poke == 2) tbl_put(1'b0, 0, 32'h0000_0000);
    for (int k = 0; k < 4 * NN && !done; k++) @(negedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic check_data(input string req);
    int bad = 0, first_bad = -1;
    logic [31:0] e;
    for (int i = 0; i < NN; i++) begin
      e = cm(cm(orig[i], ctab[i % N]), rtab[i / N]);
      if (mem[i] !== e) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (first_bad < 0) chk(1'b1, req, "results", 0, 0);
    else chk(1'b0, req, $sformatf("result at %0d", first_bad), mem[first_bad],
             cm(cm(orig[first_bad], ctab[first_bad % N]), rtab[first_bad / N]));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1", "outputs in reset",
        {busy, done, rd_en, wr_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !wr_en, "R1", "outputs idle after reset",
        {busy, done, rd_en, wr_en}, 0);
  endtask

  task automatic t_neg_one();
    load_tables(1'b1);
    fill_ram();
    run_pass(0);
    chk(first_rd == sc + 1, "R2", "first read cycle", first_rd, sc + 1);
    chk(ord_err == 0 && n_rd == NN, "R3", "raster reads", n_rd, NN);
    chk(ord_err == 0, "R3", "address order errors", ord_err, 0);
    chk(trail_err == 0 && n_wr == NN, "R5", "writes trail reads", trail_err, 0);
    chk(last_wr - first_rd + 1 == NN + LAT, "R6", "pass span",
        last_wr - first_rd + 1, NN + LAT);
    chk(n_done == 1 && done_cyc == last_wr + 1, "R7", "done cycle", done_cyc, last_wr + 1);
    chk(done_busy == 0, "R7", "busy low at done", done_busy, 0);
    check_data("R4");
    chk(mem[0] == 32'h8001_0000, "R10", "double saturation", mem[0], 32'h8001_0000);
  endtask

  task automatic t_random();
    load_tables(1'b0);
    fill_ram();
    run_pass(0);
    check_data("R4");
    chk(n_wr == NN && trail_err == 0, "R5", "write count", n_wr, NN);
    check_data("R9");
  endtask

  task automatic t_busy_start();
    fill_ram();
    run_pass(1);
    chk(n_rd == NN, "R8", "reads with start while busy", n_rd, NN);
    chk(n_done == 1, "R8", "done count", n_done, 1);
    check_data("R8");
  endtask

  task automatic t_busy_table();
    load_tables(1'b0);
    fill_ram();
    run_pass(2);
    check_data("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_neg_one();
    t_random();
    t_busy_start();
    t_busy_table();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule